// File: doc/BRIEF.md
# CPU Bus Address Decoder with Local Registers

This block sits between an 8-bit-data, 16-bit-address processor bus and the memories and peripherals behind it. For every read or write it works out which target owns the address. It raises a one-hot select for the external targets and forwards a target-relative offset with read and write strobes. It also holds a small amount of storage of its own: a fast scratch RAM near the top of the map, a boot-disable latch and an interrupt-enable register.

While the boot-disable latch is zero, a small boot program overlays the bottom 256 bytes of ROM space for reads. Software ends the overlay by writing a nonzero value to the latch. Work RAM is also visible through a mirror window. Read data comes back one cycle after the read, from a register. Any access to an address that no target owns returns 0xFF on a read, writes nothing, and raises an error pulse.

Top module: `sysbus_decoder`

## Requirements
- R1: While the boot latch is zero, a read of 0x0000..0x00FF selects the boot ROM (tgt_sel bit 0) with offset equal to the address and returns boot_rdata. A write to that range always selects the cartridge ROM (tgt_sel bit 1).
- R2: A read of 0x0000..0x00FF while the latch is nonzero, and any access to 0x0100..0x7FFF, selects the cartridge ROM (bit 1) with offset equal to the address and returns cart_rdata.
- R3: 0x8000..0x9FFF selects video RAM (bit 2) with offset address-0x8000.
- R4: 0xC000..0xDFFF selects work RAM (bit 3) with offset address-0xC000. The mirror window 0xE000..0xFDFF selects work RAM with offset address-0xE000.
- R5: 0xFF10..0xFF26 selects the sound window (bit 4) with offset address-0xFF10. 0xFF40..0xFF4B selects the display window (bit 5) with offset address-0xFF40.
- R6: Address 0xFF50 writes and reads back the full 8-bit boot latch, which is 0x00 after reset.
- R7: 0xFF80..0xFFFE is 127 bytes of local RAM. A byte reads back what was last written to it, and reads 0x00 if it has not been written since reset.
- R8: Address 0xFFFF writes and reads back the 8-bit interrupt-enable register, which is 0x00 after reset.
- R9: An access to an unmapped address raises no select and no strobe, changes no local state, and returns 0xFF on a read. bus_error is high in the cycle after each such access and low in the cycle after any cycle without a bus access.
- R10: bus_rdata is registered. It takes its new value one cycle after a read and holds it in every other cycle. It is 0x00 after reset.
- R11: At most one tgt_sel bit is high. tgt_rd and tgt_wr are high only together with a select, in the same cycle as the bus access, and tgt_wdata equals bus_wdata.
- R12: When bus_rd and bus_wr are both high, the access is a write: the target is written and bus_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rdata | output | 8 | Registered read data |
| bus_error | output | 1 | Unmapped-access pulse, one cycle late |
| tgt_sel | output | 6 | One-hot external target select |
| tgt_addr | output | 16 | Target-relative offset |
| tgt_wdata | output | 8 | Write data to the target |
| tgt_rd | output | 1 | Read strobe to the selected target |
| tgt_wr | output | 1 | Write strobe to the selected target |
| boot_rdata | input | 8 | Boot ROM read data (same cycle) |
| cart_rdata | input | 8 | Cartridge ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| snd_rdata | input | 8 | Sound window read data |
| lcd_rdata | input | 8 | Display window read data |

## Verification
Selects, offsets and strobes are combinational. The bench samples them one time step after it drives an address, inside the same cycle. bus_rdata and bus_error pass through one register each. The bench therefore samples them on the falling edge after the rising edge that ends the access, and samples again one cycle later to show that the error pulse has ended and that the data holds. Writes to local storage take effect on that same rising edge, so a read issued in the next cycle already sees them.

// File: rtl/sysbus_pkg.sv
// Package: shared address map constants, region codes and target numbering
// for the bus decoder. Assumes a 16-bit address and 8-bit data bus.
package sysbus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int N_EXT  = 6;

    localparam logic [15:0] BOOT_LAST  = 16'h00FF;
    localparam logic [15:0] ROM_LAST   = 16'h7FFF;
    localparam logic [15:0] VRAM_BASE  = 16'h8000;
    localparam logic [15:0] VRAM_LAST  = 16'h9FFF;
    localparam logic [15:0] WRAM_BASE  = 16'hC000;
    localparam logic [15:0] WRAM_LAST  = 16'hDFFF;
    localparam logic [15:0] ECHO_BASE  = 16'hE000;
    localparam logic [15:0] ECHO_LAST  = 16'hFDFF;
    localparam logic [15:0] SND_BASE   = 16'hFF10;
    localparam logic [15:0] SND_LAST   = 16'hFF26;
    localparam logic [15:0] LCD_BASE   = 16'hFF40;
    localparam logic [15:0] LCD_LAST   = 16'hFF4B;
    localparam logic [15:0] LATCH_ADDR = 16'hFF50;
    localparam logic [15:0] HRAM_BASE  = 16'hFF80;
    localparam logic [15:0] HRAM_LAST  = 16'hFFFE;
    localparam logic [15:0] IE_ADDR    = 16'hFFFF;

    localparam int HRAM_DEPTH = int'(HRAM_LAST - HRAM_BASE) + 1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_BOOT,
        RG_CART,
        RG_VRAM,
        RG_WRAM,
        RG_SND,
        RG_LCD,
        RG_LATCH,
        RG_HRAM,
        RG_IE
    } region_e;

    // Region owned by external target number idx (bit idx of tgt_sel).
    function automatic region_e ext_region(input int idx);
        case (idx)
            0:       return RG_BOOT;
            1:       return RG_CART;
            2:       return RG_VRAM;
            3:       return RG_WRAM;
            4:       return RG_SND;
            default: return RG_LCD;
        endcase
    endfunction

endpackage

// File: rtl/sysbus_region_map.sv
// Module: combinational address-to-region map.
// Turns a bus address into a region code and a target-relative offset.
// Assumes the boot overlay applies to reads only; writes to the overlay
// range go to the cartridge ROM. Addresses owned by no region map to RG_NONE.
module sysbus_region_map
    import sysbus_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          is_wr,
    input  logic          boot_off,
    output region_e       region,
    output logic [AW-1:0] offset
);

    // Priority compare of the address against each window.
    always_comb begin
        region = RG_NONE;
        offset = '0;
        if (addr <= BOOT_LAST && !boot_off && !is_wr) begin
            region = RG_BOOT;
            offset = addr;
        end else if (addr <= ROM_LAST) begin
            region = RG_CART;
            offset = addr;
        end else if (addr >= VRAM_BASE && addr <= VRAM_LAST) begin
            region = RG_VRAM;
            offset = addr - VRAM_BASE;
        end else if (addr >= WRAM_BASE && addr <= WRAM_LAST) begin
            region = RG_WRAM;
            offset = addr - WRAM_BASE;
        end else if (addr >= ECHO_BASE && addr <= ECHO_LAST) begin
            region = RG_WRAM;
            offset = addr - ECHO_BASE;
        end else if (addr >= SND_BASE && addr <= SND_LAST) begin
            region = RG_SND;
            offset = addr - SND_BASE;
        end else if (addr >= LCD_BASE && addr <= LCD_LAST) begin
            region = RG_LCD;
            offset = addr - LCD_BASE;
        end else if (addr == LATCH_ADDR) begin
            region = RG_LATCH;
        end else if (addr >= HRAM_BASE && addr <= HRAM_LAST) begin
            region = RG_HRAM;
            offset = addr - HRAM_BASE;
        end else if (addr == IE_ADDR) begin
            region = RG_IE;
        end
    end

endmodule

// File: rtl/sysbus_hram.sv
// Module: small local RAM with per-byte written flags.
// Assumes one write port and one asynchronous read port. Reset clears the
// written flags only, so an unwritten byte reads as zero after reset.
module sysbus_hram #(
    parameter int DEPTH = 127,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [DEPTH-1:0] vld;

    // Storage array: written on we, no reset needed.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Written flags: cleared by reset, set by each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (we) begin
            vld[widx] <= 1'b1;
        end
    end

    // Read port: unwritten bytes return zero.
    always_comb begin
        rdata = '0;
        if (int'(ridx) < DEPTH && vld[ridx]) begin
            rdata = mem[ridx];
        end
    end

    // R7: writes only land inside the array.
    p_hram_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(widx) < DEPTH);

    // R7: a written byte is marked valid on the next cycle.
    p_hram_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> vld[$past(widx)]);

endmodule

// File: rtl/sysbus_local_regs.sv
// Module: boot-disable latch and interrupt-enable register.
// Both are full-width, read back as written, and clear on reset. The
// overlay is active while the latch holds zero.
module sysbus_local_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_we,
    input  logic          ie_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] latch_q,
    output logic [DW-1:0] ie_q,
    output logic          boot_off
);

    // Boot-disable latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (latch_we) begin
            latch_q <= wdata;
        end
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (ie_we) begin
            ie_q <= wdata;
        end
    end

    // Overlay ends once any latch bit is set.
    assign boot_off = |latch_q;

    // R6: a latch write stores the bus data.
    p_latch_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_we |=> latch_q == $past(wdata));

    // R8: the interrupt register only changes on its own write.
    p_ie_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_we |=> $stable(ie_q));

endmodule

// File: rtl/sysbus_decoder.sv
// Module: top of the bus decoder.
// Decodes each bus access, drives the select, offset and strobes for the
// external targets, owns the local RAM and registers, and returns read data
// one cycle later through a register. Assumes external targets answer
// reads in the same cycle they are selected. A cycle with both bus_rd and
// bus_wr high is treated as a write.
module sysbus_decoder
    import sysbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_error,
    output logic [N_EXT-1:0]  tgt_sel,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              tgt_rd,
    output logic              tgt_wr,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] cart_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] wram_rdata,
    input  logic [DATA_W-1:0] snd_rdata,
    input  logic [DATA_W-1:0] lcd_rdata
);

    localparam int HIW = $clog2(HRAM_DEPTH);

    region_e           region;
    logic [ADDR_W-1:0] offset;
    logic              boot_off;
    logic              rd_fire;
    logic              any_ext;
    logic              unmapped;
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] ie_q;
    logic [DATA_W-1:0] hram_q;
    logic [DATA_W-1:0] rd_mux;

    sysbus_region_map #(.AW(ADDR_W)) u_map (
        .addr     (bus_addr),
        .is_wr    (bus_wr),
        .boot_off (boot_off),
        .region   (region),
        .offset   (offset)
    );

    sysbus_local_regs #(.DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_we (bus_wr && region == RG_LATCH),
        .ie_we    (bus_wr && region == RG_IE),
        .wdata    (bus_wdata),
        .latch_q  (latch_q),
        .ie_q     (ie_q),
        .boot_off (boot_off)
    );

    sysbus_hram #(.DEPTH(HRAM_DEPTH), .DW(DATA_W)) u_hram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && region == RG_HRAM),
        .widx  (offset[HIW-1:0]),
        .wdata (bus_wdata),
        .ridx  (offset[HIW-1:0]),
        .rdata (hram_q)
    );

    // One select bit per external target, matched against its region.
    for (genvar gi = 0; gi < N_EXT; gi++) begin : g_sel
        assign tgt_sel[gi] = (region == ext_region(gi));
    end

    // Strobes and forwarded data for the selected external target.
    assign rd_fire   = bus_rd && !bus_wr;
    assign any_ext   = |tgt_sel;
    assign unmapped  = (region == RG_NONE);
    assign tgt_addr  = offset;
    assign tgt_wdata = bus_wdata;
    assign tgt_rd    = rd_fire && any_ext;
    assign tgt_wr    = bus_wr && any_ext;

    // Read-data mux over every region; unmapped reads return all ones.
    always_comb begin
        case (region)
            RG_BOOT:  rd_mux = boot_rdata;
            RG_CART:  rd_mux = cart_rdata;
            RG_VRAM:  rd_mux = vram_rdata;
            RG_WRAM:  rd_mux = wram_rdata;
            RG_SND:   rd_mux = snd_rdata;
            RG_LCD:   rd_mux = lcd_rdata;
            RG_LATCH: rd_mux = latch_q;
            RG_HRAM:  rd_mux = hram_q;
            RG_IE:    rd_mux = ie_q;
            default:  rd_mux = '1;
        endcase
    end

    // Output register: capture read data and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_error <= 1'b0;
        end else begin
            bus_error <= (bus_rd || bus_wr) && unmapped;
            if (rd_fire) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    // R11: never more than one external target selected.
    p_onehot_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    // R9: no strobe leaves the block for an unmapped address.
    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> !tgt_wr && !tgt_rd);

    // R9: an unmapped access is flagged in the next cycle.
    p_err_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && unmapped |=> bus_error);

    // R9: an idle cycle leaves no error behind.
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_error);

    // R9: an unmapped read returns all ones.
    p_unmapped_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && unmapped |=> bus_rdata == '1);

    // R10, R12: read data only moves after a pure read.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(bus_rdata));

endmodule

// File: tb/tb_sysbus_decoder.sv
// Directed bench for sysbus_decoder: one task per scenario.
module tb_sysbus_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_error;
    logic [5:0]  tgt_sel;
    logic [15:0] tgt_addr;
    logic [7:0]  tgt_wdata;
    logic        tgt_rd, tgt_wr;
    logic [7:0]  boot_rdata, cart_rdata, vram_rdata, wram_rdata, snd_rdata, lcd_rdata;

    int n_chk = 0;
    int n_fail = 0;

    // Captured in-cycle values and registered results.
    logic [5:0]  s_sel;
    logic [15:0] s_off;
    logic        s_rd, s_wr;
    logic [7:0]  s_wdata;
    logic [7:0]  r_data;
    logic        r_err;

    always #4 clk = ~clk;

    // Target data model: distinct pattern per target, function of offset.
    function automatic logic [7:0] model(input int k, input logic [15:0] off);
        return off[7:0] ^ off[15:8] ^ (8'h1D * 8'(k + 1));
    endfunction

    assign boot_rdata = model(0, tgt_addr);
    assign cart_rdata = model(1, tgt_addr);
    assign vram_rdata = model(2, tgt_addr);
    assign wram_rdata = model(3, tgt_addr);
    assign snd_rdata  = model(4, tgt_addr);
    assign lcd_rdata  = model(5, tgt_addr);

    sysbus_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .bus_error(bus_error), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr),
        .boot_rdata(boot_rdata), .cart_rdata(cart_rdata),
        .vram_rdata(vram_rdata), .wram_rdata(wram_rdata),
        .snd_rdata(snd_rdata), .lcd_rdata(lcd_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; samples in-cycle outputs, then registered ones.
    task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                          input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        #1;
        s_sel = tgt_sel; s_off = tgt_addr; s_rd = tgt_rd; s_wr = tgt_wr;
        s_wdata = tgt_wdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        r_data = bus_rdata; r_err = bus_error;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Read an external target and check select, offset, strobe and data.
    task automatic ext_read(input logic [15:0] a, input int k,
                            input logic [15:0] off, input string req);
        access(a, 1'b1, 1'b0, 8'h00);
        chk(s_sel == 6'(1 << k), req, s_sel, 6'(1 << k));
        chk(s_off == off, req, s_off, off);
        chk(s_rd && !s_wr, req, {s_rd, s_wr}, 2'b10);
        chk(r_data == model(k, off), req, r_data, model(k, off));
        chk(!r_err, req, r_err, 0);
    endtask

    task automatic t_reset_state();
        chk(bus_rdata == 8'h00, "R10", bus_rdata, 8'h00);
        chk(!bus_error, "R9", bus_error, 0);
        access(16'hFF50, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R6", r_data, 8'h00);
        access(16'hFFFF, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R8", r_data, 8'h00);
        access(16'hFF80, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R7", r_data, 8'h00);
    endtask

    task automatic t_boot_overlay();
        ext_read(16'h0042, 0, 16'h0042, "R1");
        ext_read(16'h00FF, 0, 16'h00FF, "R1");
        ext_read(16'h0100, 1, 16'h0100, "R2");
        access(16'h0042, 1'b0, 1'b1, 8'h9C);
        chk(s_sel == 6'b000010 && s_wr, "R1", {s_sel, s_wr}, 7'b0000101);
        chk(s_wdata == 8'h9C, "R11", s_wdata, 8'h9C);
        access(16'hFF50, 1'b0, 1'b1, 8'h80);
        access(16'hFF50, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h80, "R6", r_data, 8'h80);
        ext_read(16'h0042, 1, 16'h0042, "R2");
        ext_read(16'h7FFF, 1, 16'h7FFF, "R2");
    endtask

    task automatic t_windows();
        ext_read(16'h8000, 2, 16'h0000, "R3");
        ext_read(16'h9ABC, 2, 16'h1ABC, "R3");
        ext_read(16'hC000, 3, 16'h0000, "R4");
        ext_read(16'hDFFF, 3, 16'h1FFF, "R4");
        ext_read(16'hE123, 3, 16'h0123, "R4");
        ext_read(16'hFDFF, 3, 16'h1DFF, "R4");
        ext_read(16'hFF10, 4, 16'h0000, "R5");
        ext_read(16'hFF26, 4, 16'h0016, "R5");
        ext_read(16'hFF40, 5, 16'h0000, "R5");
        ext_read(16'hFF4B, 5, 16'h000B, "R5");
    endtask

    task automatic t_local_storage();
        access(16'hFF80, 1'b0, 1'b1, 8'h3C);
        chk(s_sel == 6'b0 && !s_wr, "R11", {s_sel, s_wr}, 7'b0);
        access(16'hFFFE, 1'b0, 1'b1, 8'hE7);
        access(16'hFF80, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h3C, "R7", r_data, 8'h3C);
        access(16'hFFFE, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'hE7, "R7", r_data, 8'hE7);
        access(16'hFF81, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R7", r_data, 8'h00);
        access(16'hFFFF, 1'b0, 1'b1, 8'h1F);
        access(16'hFFFF, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h1F, "R8", r_data, 8'h1F);
    endtask

    task automatic t_unmapped();
        logic [15:0] holes [5] = '{16'hA000, 16'hFE00, 16'hFF27, 16'hFF4C, 16'hFF51};
        foreach (holes[i]) begin
            access(holes[i], 1'b1, 1'b0, 8'h00);
            chk(s_sel == 6'b0 && !s_rd, "R9", {s_sel, s_rd}, 7'b0);
            chk(r_data == 8'hFF, "R9", r_data, 8'hFF);
            chk(r_err, "R9", r_err, 1);
            @(negedge clk);
            chk(!bus_error, "R9", bus_error, 0);
        end
        access(16'hFF51, 1'b0, 1'b1, 8'h77);
        chk(!s_wr && r_err, "R9", {s_wr, r_err}, 2'b01);
        access(16'hFF50, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h80, "R9", r_data, 8'h80);
        access(16'hFFFF, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h1F, "R9", r_data, 8'h1F);
    endtask

    task automatic t_hold_and_collision();
        access(16'hFF90, 1'b0, 1'b1, 8'h55);
        access(16'hFF90, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h55, "R10", r_data, 8'h55);
        repeat (3) @(negedge clk);
        chk(bus_rdata == 8'h55, "R10", bus_rdata, 8'h55);
        access(16'hFF90, 1'b1, 1'b1, 8'hAA);
        chk(r_data == 8'h55, "R12", r_data, 8'h55);
        access(16'hFF90, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'hAA, "R12", r_data, 8'hAA);
        access(16'hC010, 1'b1, 1'b1, 8'h01);
        chk(s_wr && !s_rd, "R12", {s_wr, s_rd}, 2'b10);
    endtask

    task automatic t_reset_clears();
        do_reset();
        access(16'hFF50, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R6", r_data, 8'h00);
        access(16'hFF90, 1'b1, 1'b0, 8'h00);
        chk(r_data == 8'h00, "R7", r_data, 8'h00);
        ext_read(16'h0010, 0, 16'h0010, "R1");
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        t_reset_state();
        t_boot_overlay();
        t_windows();
        t_local_storage();
        t_unmapped();
        t_hold_and_collision();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule